// File: doc/BRIEF.md
# Selectable-Edge Pixel Input Capture

This block takes pixels from a graphics controller source bus. The bus carries a data word, a data-enable strobe and the horizontal and vertical sync strobes, all timed against one source clock. The block has two capture schemes.

In wide mode, all 24 data bits and the strobes are sampled once per clock period, on the edge that the edge-select input picks. In narrow mode, a 12-bit half word is sampled on every edge, rising and falling. The two halves of each pixel are then joined into one 24-bit word.

Whichever scheme is in use, the downstream logic sees one aligned 24-bit pixel and its strobes per clock. These outputs are registered on the rising edge only.

The output is a stream without back-pressure. The data-enable output plays the role of the valid flag, and there is no ready input, because the source cannot be held. The consumer must take a new pixel on every rising edge. The capture scheme is chosen by two configuration pins, which are read only while reset is asserted.

Top module: `pix_edge_capture`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it goes high, `px_data`, `px_de`, `px_hs` and `px_vs` are all 0.
- R2: With `cfg_narrow`=0 and `cfg_rise`=1 latched (wide mode, rising edge), the word on `in_data[23:0]` at rising edge k appears on `px_data` just after rising edge k+1. A value held only around the falling edge has no effect.
- R3: With `cfg_narrow`=0 and `cfg_rise`=0 latched (wide mode, falling edge), the word on `in_data` at the falling edge that follows rising edge k appears on `px_data` just after rising edge k+1. A value held only around a rising edge has no effect.
- R4: With `cfg_narrow`=1 latched (narrow mode), `px_data[11:0]` comes from `in_data[11:0]` at rising edge k. `px_data[23:12]` comes from `in_data[11:0]` at the falling edge that follows it. Both appear just after rising edge k+1.
- R5: In narrow mode, `in_data[23:12]` has no effect on any output.
- R6: `px_de`, `px_hs` and `px_vs` follow the same timing as the data. They are taken from the rising-edge sample in narrow mode and in wide rising mode, and from the falling-edge sample in wide falling mode.
- R7: `cfg_narrow` and `cfg_rise` are sampled only on rising edges while `rst_n` is low. Changing them while running leaves the capture scheme unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock. Both edges capture; the output register uses the rising edge |
| rst_n | input | 1 | Active-low synchronous reset. The configuration is latched while it is low |
| cfg_narrow | input | 1 | 1 selects narrow mode (12-bit, both edges); 0 selects wide mode (24-bit, one edge) |
| cfg_rise | input | 1 | Wide mode only: 1 captures on the rising edge, 0 on the falling edge |
| in_data | input | 24 | Source pixel bus. Only bits 11:0 are used in narrow mode |
| in_de | input | 1 | Source data enable |
| in_hs | input | 1 | Source horizontal sync |
| in_vs | input | 1 | Source vertical sync |
| px_data | output | 24 | Aligned output pixel |
| px_de | output | 1 | Output data enable; acts as the stream valid flag |
| px_hs | output | 1 | Output horizontal sync |
| px_vs | output | 1 | Output vertical sync |

## Verification
The falling-edge sample and the rising-edge sample of one pixel are merged into the same output register on the same rising edge. A mix-up between the two edges is therefore the main risk. The bench drives a different data word and a different strobe set just before each rising edge and just before each falling edge. The edge that is not selected thus always holds a decoy value. Each output is then compared with the word that the latched mode says must win: the low half from the rising sample and the high half from the falling sample in narrow mode, and only the chosen edge in wide mode.

// File: rtl/pxc_pkg.sv
`timescale 1ns/1ps
package pxc_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE_RISE = 2'd0,
    MODE_WIDE_FALL = 2'd1,
    MODE_NARROW    = 2'd2
  } cap_mode_e;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  function automatic cap_mode_e decode_mode(input logic narrow, input logic rise);
    if (narrow)    return MODE_NARROW;
    else if (rise) return MODE_WIDE_RISE;
    else           return MODE_WIDE_FALL;
  endfunction

endpackage

// File: rtl/pxc_cfg_latch.sv
`timescale 1ns/1ps
module pxc_cfg_latch
  import pxc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_narrow,
  input  logic      cfg_rise,
  output cap_mode_e mode
);

  // configuration is only followed while reset holds; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= decode_mode(cfg_narrow, cfg_rise);
  end

endmodule

// File: rtl/pxc_edge_cap.sv
`timescale 1ns/1ps
module pxc_edge_cap #(
  parameter int unsigned W       = 27,
  parameter bit          FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/pxc_merge.sv
`timescale 1ns/1ps
module pxc_merge
  import pxc_pkg::*;
#(
  parameter int unsigned HALF_W = 12,
  localparam int unsigned PIX_W = 2 * HALF_W,
  localparam int unsigned SMP_W = PIX_W + CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_mode_e        mode,
  input  logic [SMP_W-1:0] rise_q,
  input  logic [SMP_W-1:0] fall_q,
  output logic [PIX_W-1:0] px_data,
  output ctl_t             px_ctl
);

  logic [PIX_W-1:0] nxt_data;
  ctl_t             nxt_ctl;

  always_comb begin
    case (mode)
      MODE_NARROW: begin
        nxt_data = {fall_q[HALF_W-1:0], rise_q[HALF_W-1:0]};
        nxt_ctl  = ctl_t'(rise_q[SMP_W-1 -: CTL_W]);
      end
      MODE_WIDE_FALL: begin
        nxt_data = fall_q[PIX_W-1:0];
        nxt_ctl  = ctl_t'(fall_q[SMP_W-1 -: CTL_W]);
      end
      default: begin
        nxt_data = rise_q[PIX_W-1:0];
        nxt_ctl  = ctl_t'(rise_q[SMP_W-1 -: CTL_W]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_data <= '0;
      px_ctl  <= '0;
    end else begin
      px_data <= nxt_data;
      px_ctl  <= nxt_ctl;
    end
  end

endmodule

// File: rtl/pix_edge_capture.sv
`timescale 1ns/1ps
module pix_edge_capture
  import pxc_pkg::*;
#(
  parameter int unsigned HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_narrow,
  input  logic                cfg_rise,
  input  logic [2*HALF_W-1:0] in_data,
  input  logic                in_de,
  input  logic                in_hs,
  input  logic                in_vs,
  output logic [2*HALF_W-1:0] px_data,
  output logic                px_de,
  output logic                px_hs,
  output logic                px_vs
);

  localparam int unsigned PIX_W = 2 * HALF_W;
  localparam int unsigned SMP_W = PIX_W + CTL_W;

  cap_mode_e        mode;
  logic [SMP_W-1:0] smp_d;
  logic [SMP_W-1:0] rise_q;
  logic [SMP_W-1:0] fall_q;
  ctl_t             out_ctl;

  assign smp_d = {in_de, in_hs, in_vs, in_data};

  pxc_cfg_latch u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_narrow (cfg_narrow),
    .cfg_rise   (cfg_rise),
    .mode       (mode)
  );

  pxc_edge_cap #(.W(SMP_W), .FALLING(1'b0)) u_cap_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (smp_d),
    .q     (rise_q)
  );

  pxc_edge_cap #(.W(SMP_W), .FALLING(1'b1)) u_cap_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (smp_d),
    .q     (fall_q)
  );

  pxc_merge #(.HALF_W(HALF_W)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .px_data (px_data),
    .px_ctl  (out_ctl)
  );

  assign px_de = out_ctl.de;
  assign px_hs = out_ctl.hs;
  assign px_vs = out_ctl.vs;

endmodule

// File: rtl/pix_edge_capture_chk.sv
`timescale 1ns/1ps
module pix_edge_capture_chk
  import pxc_pkg::*;
#(
  parameter int unsigned HALF_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input cap_mode_e           mode,
  input logic [2*HALF_W-1:0] in_data,
  input logic                in_de,
  input logic                in_hs,
  input logic                in_vs,
  input logic [2*HALF_W-1:0] px_data,
  input logic                px_de,
  input logic                px_hs,
  input logic                px_vs
);

  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (px_data == '0 && !px_de && !px_hs && !px_vs));

  // R2
  wide_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDE_RISE && run_cnt >= 2'd2) |-> px_data == $past(in_data, 2));

  // R4
  narrow_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NARROW && run_cnt >= 2'd2)
      |-> px_data[HALF_W-1:0] == $past(in_data[HALF_W-1:0], 2));

  // R6
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_WIDE_FALL && run_cnt >= 2'd2)
      |-> {px_de, px_hs, px_vs} == $past({in_de, in_hs, in_vs}, 2));

endmodule

bind pix_edge_capture pix_edge_capture_chk #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .in_data (in_data),
  .in_de   (in_de),
  .in_hs   (in_hs),
  .in_vs   (in_vs),
  .px_data (px_data),
  .px_de   (px_de),
  .px_hs   (px_hs),
  .px_vs   (px_vs)
);

// File: tb/test_pix_edge_capture.sv
`timescale 1ns/1ps
module test_pix_edge_capture;

  localparam int unsigned HALF_W = 12;
  localparam int unsigned PIX_W  = 2 * HALF_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_narrow = 1'b0;
  logic             cfg_rise = 1'b1;
  logic [PIX_W-1:0] in_data = '0;
  logic             in_de = 1'b0;
  logic             in_hs = 1'b0;
  logic             in_vs = 1'b0;
  logic [PIX_W-1:0] px_data;
  logic             px_de;
  logic             px_hs;
  logic             px_vs;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  pix_edge_capture #(.HALF_W(HALF_W)) i_pix_edge_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_narrow (cfg_narrow),
    .cfg_rise   (cfg_rise),
    .in_data    (in_data),
    .in_de      (in_de),
    .in_hs      (in_hs),
    .in_vs      (in_vs),
    .px_data    (px_data),
    .px_de      (px_de),
    .px_hs      (px_hs),
    .px_vs      (px_vs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reset with the given configuration; returns just after a falling edge
  task automatic do_reset(input bit narrow, input bit rise);
    rst_n      = 1'b0;
    cfg_narrow = narrow;
    cfg_rise   = rise;
    repeat (4) @(posedge clk);
    #1;
    check("R1 data in reset", {8'h0, px_data}, 32'h0);
    check("R1 strobes in reset", {29'h0, px_de, px_hs, px_vs}, 32'h0);
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Drives A before each rising edge and B before each falling edge.
  // pat 0: random values; pat 1: alternating all-ones / all-zeros extremes.
  task automatic run_stream(input int n, input bit narrow, input bit rise,
                            input bit flip_cfg, input int pat, input string req);
    logic [PIX_W-1:0] exp_d;
    logic [2:0]       exp_c;
    logic [PIX_W-1:0] a_d, b_d;
    logic [2:0]       a_c, b_c;
    exp_d = '0;
    exp_c = '0;
    for (int i = 0; i < n; i++) begin
      if (pat == 1) begin
        a_d = i[0] ? '1 : '0;
        a_c = i[0] ? 3'b111 : 3'b000;
      end else begin
        a_d = $urandom();
        a_c = 3'($urandom());
      end
      b_d = ~a_d;
      b_c = ~a_c;
      in_data = a_d;
      {in_de, in_hs, in_vs} = a_c;
      @(posedge clk);
      #1;
      if (i == 0) begin
        check("R1 first edge after reset data", {8'h0, px_data}, 32'h0);
        check("R1 first edge after reset strobes", {29'h0, px_de, px_hs, px_vs}, 32'h0);
      end else begin
        check(req, {8'h0, px_data}, {8'h0, exp_d});
        check("R6 strobes", {29'h0, px_de, px_hs, px_vs}, {29'h0, exp_c});
      end
      in_data = b_d;
      {in_de, in_hs, in_vs} = b_c;
      if (narrow) begin
        exp_d = {b_d[HALF_W-1:0], a_d[HALF_W-1:0]};
        exp_c = a_c;
      end else if (rise) begin
        exp_d = a_d;
        exp_c = a_c;
      end else begin
        exp_d = b_d;
        exp_c = b_c;
      end
      if (flip_cfg && i == 3) begin
        cfg_narrow = ~cfg_narrow;
        cfg_rise   = ~cfg_rise;
      end
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    check(req, {8'h0, px_data}, {8'h0, exp_d});
    check("R6 strobes last", {29'h0, px_de, px_hs, px_vs}, {29'h0, exp_c});
  endtask

  task automatic t_wide_rise();
    do_reset(1'b0, 1'b1);
    run_stream(20, 1'b0, 1'b1, 1'b0, 0, "R2 wide rising");
  endtask

  task automatic t_wide_fall();
    do_reset(1'b0, 1'b0);
    run_stream(20, 1'b0, 1'b0, 1'b0, 0, "R3 wide falling");
  endtask

  task automatic t_narrow();
    do_reset(1'b1, 1'b0);
    run_stream(20, 1'b1, 1'b0, 1'b0, 0, "R4 R5 narrow join");
  endtask

  task automatic t_narrow_extremes();
    do_reset(1'b1, 1'b1);
    run_stream(8, 1'b1, 1'b1, 1'b0, 1, "R4 R5 narrow extremes");
  endtask

  task automatic t_wide_fall_extremes();
    do_reset(1'b0, 1'b0);
    run_stream(8, 1'b0, 1'b0, 1'b0, 1, "R3 wide falling extremes");
  endtask

  task automatic t_cfg_frozen();
    do_reset(1'b0, 1'b1);
    run_stream(12, 1'b0, 1'b1, 1'b1, 0, "R7 wide rising kept after cfg change");
    do_reset(1'b1, 1'b0);
    run_stream(12, 1'b1, 1'b0, 1'b1, 0, "R7 narrow kept after cfg change");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_wide_rise();
    t_wide_fall();
    t_narrow();
    t_narrow_extremes();
    t_wide_fall_extremes();
    t_cfg_frozen();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule